// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block sits beside a small 8-bit processor core. It holds the interrupt status and interrupt mask registers. A built-in timer raises status bit 0 once per period, and the core can raise any status bit by software. Whenever the core signals an instruction boundary, the block checks the status bits that the mask enables. If any is set, it takes over the memory port and saves the context on the stack. The stack grows downward, and the pushes come in this order: program counter, flags, R0 to R4, then the mask (as R5) and the status (as R6). It then fetches the handler address from a vector table in memory and hands the new PC and SP to the core.

When the core executes a return-from-interrupt, the block unwinds the same frame. It hands back the register values one per cycle, R6 first, then the flags, and finally the PC and the new SP. It then re-enables every interrupt source. While either sequence runs, `busy` stalls the core. The memory port makes one access per cycle, and reads return data on the cycle after the address.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, status and mask are zero, `busy` is low and no memory access is made.
- R2: The timer sets status bit 0 at the clock edge that ends every TICK_CYCLES-th cycle counted from reset release.
- R3: A cycle with `swi_valid` high sets status bit `swi_num`. A bit that is set and cleared in the same cycle ends up set.
- R4: An entry starts in a cycle S only if the block is idle, `boundary` is high and (status AND mask) is nonzero. `busy` is high from cycle S through S+11 and low in S+12.
- R5: Entry services only the lowest-numbered pending bit and clears that bit at the end of cycle S. All other bits are kept.
- R6: In cycles S+1 to S+9, entry writes nine bytes to addresses SP-1 down to SP-9. The order is PC, FL, R0, R1, R2, R3, R4, mask, status, with SP taken in cycle S.
- R7: Entry reads address VEC_BASE plus the interrupt number in S+10 (VEC_BASE defaults to 0xF8). In S+11 it presents that byte with `pc_load` and presents SP-9 with `sp_load`. The mask reads zero from S+12.
- R8: A cycle with `mask_wr_en` high loads `mask_wr_data` into the mask, unless an entry or return finishes in that cycle.
- R9: A return starts in cycle S when the block is idle, `iret_req` is high and no entry starts. It reads SP, SP+1, ... SP+8 in S+1 to S+9. It writes R6 down to R0 in S+2 to S+8 and presents FL in S+9. In S+10 it presents the PC and SP+9. `busy` is high from S through S+10, and the mask reads all ones from S+11.
- R10: No memory access is made while idle, and a single cycle never both reads and writes.
- R11: `iret_req` and `boundary` have no effect while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Core is between instructions and about to fetch |
| iret_req | input | 1 | Core executes return-from-interrupt |
| swi_valid | input | 1 | Software interrupt request |
| swi_num | input | 3 | Status bit to set for a software request |
| mask_wr_en | input | 1 | Core writes the mask register |
| mask_wr_data | input | 8 | New mask value |
| sp_in | input | 8 | Current stack pointer |
| pc_in | input | 8 | PC of the next instruction |
| fl_in | input | 8 | Flags register |
| gpr_in | input | 40 | R0 to R4, R0 in bits 7:0 |
| mem_addr | output | 8 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| busy | output | 1 | Core must stall |
| pc_load | output | 1 | Load `pc_out` into the PC |
| pc_out | output | 8 | New PC value |
| fl_load | output | 1 | Load `fl_out` into the flags |
| fl_out | output | 8 | Restored flags |
| reg_wr_en | output | 1 | Register restore strobe |
| reg_wr_idx | output | 3 | Register being restored |
| reg_wr_data | output | 8 | Restored register value |
| sp_load | output | 1 | Load `sp_out` into SP |
| sp_out | output | 8 | New stack pointer |
| status_out | output | 8 | Interrupt status register |
| mask_out | output | 8 | Interrupt mask register |

## Verification
Two functions can land on the same status bit in one cycle. One is the clearing of the serviced bit at entry start. The other is setting a bit, either by the timer tick or by a software request. The bench provokes this by raising `swi_valid` in the very cycle that `boundary` starts an entry, with `swi_num` equal to the bit the entry will service. The timer phase is also shifted across repeated entry/return rounds, so that ticks fall inside running sequences. Every cycle, the reference model's status, mask, busy and memory traffic are compared with the ports, and the re-set bit must still read as pending after the entry.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PUSH,
    SQ_VEC,
    SQ_VWAIT,
    SQ_POP,
    SQ_PLAST
  } sq_state_e;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int TICK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             swi_valid,
  input  logic [IDX_W-1:0] swi_num,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             mask_wr_en,
  input  logic [W-1:0]     mask_wr_data,
  input  logic             mask_zero,
  input  logic             mask_ones,
  output logic [W-1:0]     status_q,
  output logic [W-1:0]     mask_q,
  output logic             pend_any,
  output logic [IDX_W-1:0] pend_idx
);
  logic [W-1:0] set_vec, clr_vec, pend;

  always_comb begin
    set_vec = '0;
    set_vec[0] = tick;
    if (swi_valid) set_vec[swi_num] = 1'b1;
    clr_vec = '0;
    if (clr_en) clr_vec[clr_idx] = 1'b1;
  end

  assign pend     = status_q & mask_q;
  assign pend_any = |pend;

  always_comb begin
    pend_idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend[i]) pend_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (mask_zero)       mask_q <= '0;
      else if (mask_ones)  mask_q <= '1;
      else if (mask_wr_en) mask_q <= mask_wr_data;
    end
  end

  // R2
  tick_sets_bit0_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> status_q[0]);
  // R3
  swi_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
    swi_valid |=> status_q[$past(swi_num)]);
  // R5
  serviced_bit_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(tick && clr_idx == '0) && !(swi_valid && swi_num == clr_idx))
    |=> !status_q[$past(clr_idx)]);
  // R7
  mask_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    mask_zero |=> (mask_q == '0));
  // R9
  mask_reopened_chk: assert property (@(posedge clk) disable iff (rst)
    mask_ones |=> (mask_q == '1));
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_seq_pkg::*;
#(
  parameter int          W        = 8,
  parameter int          NUM_GPR  = 7,
  parameter logic [7:0]  VEC_BASE = 8'hF8,
  localparam int IDX_W  = $clog2(W),
  localparam int SLOTS  = NUM_GPR + 2,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int GIDX_W = $clog2(NUM_GPR),
  localparam int LOWG   = NUM_GPR - 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                boundary,
  input  logic                iret_req,
  input  logic                pend_any,
  input  logic [IDX_W-1:0]    pend_idx,
  input  logic [W-1:0]        sp_in,
  input  logic [W-1:0]        pc_in,
  input  logic [W-1:0]        fl_in,
  input  logic [LOWG*W-1:0]   gpr_in,
  input  logic [W-1:0]        mask_q,
  input  logic [W-1:0]        status_q,
  output logic [W-1:0]        mem_addr,
  output logic                mem_we,
  output logic [W-1:0]        mem_wdata,
  output logic                mem_re,
  input  logic [W-1:0]        mem_rdata,
  output logic                busy,
  output logic                pc_load,
  output logic                fl_load,
  output logic                reg_wr_en,
  output logic [GIDX_W-1:0]   reg_wr_idx,
  output logic                sp_load,
  output logic [W-1:0]        sp_out,
  output logic                clr_en,
  output logic [IDX_W-1:0]    clr_idx,
  output logic                mask_zero,
  output logic                mask_ones
);
  sq_state_e        state_q;
  logic [CNT_W-1:0] k_q;
  logic [W-1:0]     sp_q;
  logic [IDX_W-1:0] num_q;
  logic             start_e, start_i;
  logic [W-1:0]     slot_d [SLOTS];
  logic [CNT_W-1:0] ridx;

  // frame slots: PC, FL, low GPRs, then mask and status in the R5/R6 places
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_pc
      assign slot_d[g] = pc_in;
    end else if (g == 1) begin : g_fl
      assign slot_d[g] = fl_in;
    end else if (g < LOWG + 2) begin : g_gpr
      assign slot_d[g] = gpr_in[(g-2)*W +: W];
    end else if (g == LOWG + 2) begin : g_mask
      assign slot_d[g] = mask_q;
    end else begin : g_stat
      assign slot_d[g] = status_q;
    end
  end

  assign start_e = (state_q == SQ_IDLE) && boundary && pend_any;
  assign start_i = (state_q == SQ_IDLE) && !start_e && iret_req;
  assign busy    = (state_q != SQ_IDLE) || start_e || start_i;
  assign clr_en  = start_e;
  assign clr_idx = pend_idx;

  assign mem_we    = (state_q == SQ_PUSH);
  assign mem_re    = (state_q == SQ_VEC) || (state_q == SQ_POP);
  assign mem_wdata = (k_q < CNT_W'(SLOTS)) ? slot_d[k_q] : '0;

  always_comb begin
    case (state_q)
      SQ_PUSH: mem_addr = sp_q - 1'b1;
      SQ_VEC:  mem_addr = VEC_BASE + {{(W-IDX_W){1'b0}}, num_q};
      SQ_POP:  mem_addr = sp_q;
      default: mem_addr = '0;
    endcase
  end

  assign ridx       = CNT_W'(NUM_GPR) - k_q;
  assign reg_wr_idx = ridx[GIDX_W-1:0];
  assign reg_wr_en  = (state_q == SQ_POP) && (k_q != '0) && (k_q <= CNT_W'(NUM_GPR));
  assign fl_load    = (state_q == SQ_POP) && (k_q == CNT_W'(SLOTS - 1));
  assign pc_load    = (state_q == SQ_VWAIT) || (state_q == SQ_PLAST);
  assign sp_load    = pc_load;
  assign sp_out     = sp_q;
  assign mask_zero  = (state_q == SQ_VWAIT);
  assign mask_ones  = (state_q == SQ_PLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      k_q     <= '0;
      sp_q    <= '0;
      num_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          k_q <= '0;
          if (start_e) begin
            num_q   <= pend_idx;
            sp_q    <= sp_in;
            state_q <= SQ_PUSH;
          end else if (start_i) begin
            sp_q    <= sp_in;
            state_q <= SQ_POP;
          end
        end
        SQ_PUSH: begin
          sp_q <= sp_q - 1'b1;
          k_q  <= k_q + 1'b1;
          if (k_q == CNT_W'(SLOTS - 1)) state_q <= SQ_VEC;
        end
        SQ_VEC:   state_q <= SQ_VWAIT;
        SQ_VWAIT: state_q <= SQ_IDLE;
        SQ_POP: begin
          sp_q <= sp_q + 1'b1;
          k_q  <= k_q + 1'b1;
          if (k_q == CNT_W'(SLOTS - 1)) state_q <= SQ_PLAST;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_re));
  // R10
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
  // R6
  push_descends_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));
  // R9
  pop_ascends_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && $past(reg_wr_en)) |-> (reg_wr_idx == $past(reg_wr_idx) - 1'b1));
  // R4
  busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |=> busy);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          W           = 8,
  parameter int          NUM_GPR     = 7,
  parameter logic [7:0]  VEC_BASE    = 8'hF8,
  parameter int          TICK_CYCLES = 1000,
  localparam int IDX_W  = $clog2(W),
  localparam int GIDX_W = $clog2(NUM_GPR),
  localparam int LOWG   = NUM_GPR - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              iret_req,
  input  logic              swi_valid,
  input  logic [IDX_W-1:0]  swi_num,
  input  logic              mask_wr_en,
  input  logic [W-1:0]      mask_wr_data,
  input  logic [W-1:0]      sp_in,
  input  logic [W-1:0]      pc_in,
  input  logic [W-1:0]      fl_in,
  input  logic [LOWG*W-1:0] gpr_in,
  output logic [W-1:0]      mem_addr,
  output logic              mem_we,
  output logic [W-1:0]      mem_wdata,
  output logic              mem_re,
  input  logic [W-1:0]      mem_rdata,
  output logic              busy,
  output logic              pc_load,
  output logic [W-1:0]      pc_out,
  output logic              fl_load,
  output logic [W-1:0]      fl_out,
  output logic              reg_wr_en,
  output logic [GIDX_W-1:0] reg_wr_idx,
  output logic [W-1:0]      reg_wr_data,
  output logic              sp_load,
  output logic [W-1:0]      sp_out,
  output logic [W-1:0]      status_out,
  output logic [W-1:0]      mask_out
);
  logic             tick, pend_any, clr_en, mask_zero, mask_ones;
  logic [IDX_W-1:0] pend_idx, clr_idx;

  irq_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  irq_status_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .tick(tick),
    .swi_valid(swi_valid), .swi_num(swi_num),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .mask_zero(mask_zero), .mask_ones(mask_ones),
    .status_q(status_out), .mask_q(mask_out),
    .pend_any(pend_any), .pend_idx(pend_idx)
  );

  irq_ctx_seq #(.W(W), .NUM_GPR(NUM_GPR), .VEC_BASE(VEC_BASE)) u_seq (
    .clk(clk), .rst(rst), .boundary(boundary), .iret_req(iret_req),
    .pend_any(pend_any), .pend_idx(pend_idx),
    .sp_in(sp_in), .pc_in(pc_in), .fl_in(fl_in), .gpr_in(gpr_in),
    .mask_q(mask_out), .status_q(status_out),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata),
    .busy(busy), .pc_load(pc_load), .fl_load(fl_load),
    .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
    .sp_load(sp_load), .sp_out(sp_out),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .mask_zero(mask_zero), .mask_ones(mask_ones)
  );

  assign pc_out      = mem_rdata;
  assign fl_out      = mem_rdata;
  assign reg_wr_data = mem_rdata;
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int P = 50;
  localparam logic [7:0] VB = 8'hF8;

  logic clk = 0, rst = 1;
  logic boundary = 0, iret_req = 0, swi_valid = 0, mask_wr_en = 0;
  logic [2:0] swi_num = 0;
  logic [7:0] mask_wr_data = 0, sp_in = 8'hF4, pc_in = 8'h11, fl_in = 8'h02;
  logic [39:0] gpr_in = 40'h5544332211;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, pc_out, fl_out, reg_wr_data, sp_out;
  logic [7:0] status_out, mask_out;
  logic mem_we, mem_re, busy, pc_load, fl_load, reg_wr_en, sp_load;
  logic [2:0] reg_wr_idx;

  logic [7:0] bmem [256];
  int checks = 0, fails = 0;

  // model state
  logic [7:0] m_status, m_mask, m_sp;
  int m_tcnt, m_left, m_kind, m_num;

  always #2.5 clk = ~clk;

  irq_entry_seq #(.TICK_CYCLES(P)) u_dut (
    .clk(clk), .rst(rst), .boundary(boundary), .iret_req(iret_req),
    .swi_valid(swi_valid), .swi_num(swi_num), .mask_wr_en(mask_wr_en),
    .mask_wr_data(mask_wr_data), .sp_in(sp_in), .pc_in(pc_in), .fl_in(fl_in),
    .gpr_in(gpr_in), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .pc_load(pc_load),
    .pc_out(pc_out), .fl_load(fl_load), .fl_out(fl_out), .reg_wr_en(reg_wr_en),
    .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data), .sp_load(sp_load),
    .sp_out(sp_out), .status_out(status_out), .mask_out(mask_out)
  );

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= bmem[mem_addr];
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowbit(logic [7:0] v);
    int r = -1;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  task automatic cyc();
    logic se, si, e_we, e_re, e_pcl, e_fll, e_rwe;
    logic [7:0] e_addr, e_data, e_pc, e_sp, e_fl, e_rd, pend, setv, clrv;
    int j, e_idx;
    #1;
    pend = m_status & m_mask;
    se = (m_left == 0) && boundary && (pend != 0);
    si = (m_left == 0) && !se && iret_req;
    check("R4 busy", busy, se || si || m_left > 0);
    check("R5 status", status_out, m_status);
    check("R8 mask", mask_out, m_mask);
    e_we = 0; e_re = 0; e_pcl = 0; e_fll = 0; e_rwe = 0;
    e_addr = 0; e_data = 0; e_pc = 0; e_sp = 0; e_fl = 0; e_rd = 0; e_idx = 0;
    if (m_kind == 0 && m_left >= 3) begin
      j = 11 - m_left; e_we = 1; e_addr = 8'(m_sp - 1 - j);
      case (j)
        0: e_data = pc_in;
        1: e_data = fl_in;
        7: e_data = m_mask;
        8: e_data = m_status;
        default: e_data = gpr_in[(j-2)*8 +: 8];
      endcase
    end
    if (m_kind == 0 && m_left == 2) begin e_re = 1; e_addr = 8'(VB + m_num); end
    if (m_kind == 0 && m_left == 1) begin
      e_pcl = 1; e_pc = bmem[8'(VB + m_num)]; e_sp = 8'(m_sp - 9);
    end
    if (m_kind == 1 && m_left >= 2) begin e_re = 1; e_addr = 8'(m_sp + 10 - m_left); end
    if (m_kind == 1 && m_left >= 3 && m_left <= 9) begin
      e_rwe = 1; e_idx = m_left - 3; e_rd = bmem[8'(m_sp + 9 - m_left)];
    end
    if (m_kind == 1 && m_left == 2) begin e_fll = 1; e_fl = bmem[8'(m_sp + 7)]; end
    if (m_kind == 1 && m_left == 1) begin
      e_pcl = 1; e_pc = bmem[8'(m_sp + 8)]; e_sp = 8'(m_sp + 9);
    end
    // R10: no access unless a sequence calls for it
    check(m_left == 0 ? "R10 mem_we" : "R6 mem_we", mem_we, e_we);
    check(m_left == 0 ? "R10 mem_re" : "R7/R9 mem_re", mem_re, e_re);
    if (e_we) begin check("R6 push addr", mem_addr, e_addr); check("R6 push data", mem_wdata, e_data); end
    if (e_re) check(m_kind == 0 ? "R7 vec addr" : "R9 pop addr", mem_addr, e_addr);
    check("R7/R9 pc_load", pc_load, e_pcl);
    check("R7/R9 sp_load", sp_load, e_pcl);
    if (e_pcl) begin check("R7/R9 pc_out", pc_out, e_pc); check("R7/R9 sp_out", sp_out, e_sp); end
    check("R9 fl_load", fl_load, e_fll);
    if (e_fll) check("R9 fl_out", fl_out, e_fl);
    check("R9 reg_wr_en", reg_wr_en, e_rwe);
    if (e_rwe) begin check("R9 reg idx", reg_wr_idx, e_idx); check("R9 reg data", reg_wr_data, e_rd); end
    // model advance to the next edge
    setv = 0;
    if (m_tcnt == P - 1) begin setv[0] = 1; m_tcnt = 0; end else m_tcnt++;
    if (swi_valid) setv[swi_num] = 1;
    clrv = 0;
    if (se) clrv[lowbit(pend)] = 1;
    if (m_kind == 0 && m_left == 1) m_mask = 8'h00;
    else if (m_kind == 1 && m_left == 1) m_mask = 8'hFF;
    else if (mask_wr_en) m_mask = mask_wr_data;
    m_status = (m_status & ~clrv) | setv;
    if (se) begin m_left = 11; m_kind = 0; m_sp = sp_in; m_num = lowbit(pend); end
    else if (si) begin m_left = 10; m_kind = 1; m_sp = sp_in; end
    else if (m_left > 0) m_left--;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    for (int a = 0; a < 256; a++) bmem[a] = 8'(a ^ 8'h5A);
    for (int v = 0; v < 8; v++) bmem[8'(VB + v)] = 8'(8'h40 + v * 4);
    m_status = 0; m_mask = 0; m_sp = 0; m_tcnt = 0; m_left = 0; m_kind = 0; m_num = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 status", status_out, 0);
    check("R1 mask", mask_out, 0);
    check("R1 mem_we", mem_we, 0);
    // mask zero: boundary alone starts nothing; timer tick lands
    boundary = 1;
    repeat (60) cyc();
    boundary = 0;
    check("R2 tick bit0", status_out[0], 1);
    swi_valid = 1; swi_num = 3; cyc();
    swi_num = 5; cyc();
    swi_valid = 0;
    check("R3 swi bits", status_out, 8'h29);
    mask_wr_en = 1; mask_wr_data = 8'h28; cyc(); mask_wr_en = 0;
    boundary = 1; cyc(); boundary = 0;
    cyc(); cyc();
    iret_req = 1; cyc(); iret_req = 0;   // R11: ignored mid-entry
    repeat (12) cyc();
    check("R5 bit3 cleared", status_out[3], 0);
    check("R5 bit5 kept", status_out[5], 1);
    check("R11 idle after entry", busy, 0);
    pc_in = 8'h77; sp_in = 8'hEB;
    iret_req = 1; cyc(); iret_req = 0;
    repeat (11) cyc();
    check("R9 mask reopened", mask_out, 8'hFF);
    sp_in = 8'hF4;
    // same-cycle clear and set of the serviced bit
    n = lowbit(m_status & m_mask);
    boundary = 1; swi_valid = 1; swi_num = 3'(n < 0 ? 2 : n); cyc();
    boundary = 0; swi_valid = 0;
    check("R3 set beats clear", status_out[swi_num], 1);
    repeat (13) cyc();
    sp_in = 8'hEB; iret_req = 1; cyc(); iret_req = 0; repeat (11) cyc();
    for (int i = 0; i < 6; i++) begin
      pc_in = 8'(8'h20 + i); fl_in = 8'(i); gpr_in = {5{8'(8'hA0 + i)}} ^ 40'h0102030405;
      sp_in = 8'hF4; swi_valid = (i % 2 == 0); swi_num = 3'(i + 1);
      boundary = 1; cyc(); boundary = 0; swi_valid = 0;
      repeat (12) cyc();
      sp_in = 8'hEB; iret_req = 1; cyc(); iret_req = 0;
      repeat (11 + i * 7) cyc();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule